// File: doc/BRIEF.md
# Counted-Sequence Summing Engine

The engine adds up a run of unsigned words that arrive one at a time on an input bus under a two-wire handshake. The first word of each run is not data: it gives the number of data words that follow. The engine clears its running sum, keeps that number in a count register, and then takes in exactly that many words. Each accepted word is added into the sum and the count goes down by one. When the count reaches zero the engine goes back to idle. The sum stays on the output bus and a done flag is raised.

A producer puts a word on `in_bus` and raises `data_vld` while `rdy` is high. The engine answers with a one-cycle `ack`. The producer must then lower `data_vld` before the next word is taken. Inside, a controller sends clear, load and decrement strobes to a datapath. The datapath returns a zero flag for the count and the carry out of its adder. The adder carry is kept as a sticky `ovf` flag for the current run.

The controller has five states:
- `ST_IDLE`: `rdy` is high and the engine waits for a count word. Seeing `data_vld` high, it goes to `ST_CNT_ACK`.
- `ST_CNT_ACK`: `ack` is high for one cycle. It always moves on to `ST_RELEASE`.
- `ST_RELEASE`: `rdy` is low and the engine waits for `data_vld` to drop. When it drops, the engine goes to `ST_IDLE` if the count is zero, and to `ST_FETCH` otherwise.
- `ST_FETCH`: `rdy` is high and the engine waits for a data word. Seeing `data_vld` high, it goes to `ST_ADD_ACK`.
- `ST_ADD_ACK`: `ack` is high for one cycle. It always moves on to `ST_RELEASE`.

Top module: `seqsum_top`

## Requirements
- R1: After reset, `rdy`=1, `ack`=0, `out_bus`=0, `ovf`=0 and `done`=1 (the count is zero).
- R2: A word accepted in idle (`rdy`=1 and `data_vld`=1 at a clock edge) loads the count from `in_bus`, clears the sum and clears `ovf`. `ack` is high in the following cycle.
- R3: Each accepted word gives exactly one `ack` cycle, however long `data_vld` is held high.
- R4: After an `ack`, `rdy` stays low and no word is accepted until `data_vld` has been seen low. The engine then raises `rdy` the cycle after it sees the drop.
- R5: Each data word accepted while the count is nonzero is added into the sum, modulo 2^WORD_W, and the count drops by one. `out_bus` shows the sum at all times.
- R6: `done` is 0 while data words remain. Once the last one is released, the engine is in idle with `rdy`=1 and `done`=1.
- R7: `ovf` goes to 1 when any addition in the current run carries out of WORD_W bits. It stays at 1 until the next count word is loaded.
- R8: A count word of zero ends the run at once: after release, the sum is 0 and the engine is idle with `done`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_bus | input | WORD_W | Count word or data word |
| data_vld | input | 1 | Producer has a word on `in_bus` |
| out_bus | output | WORD_W | Running sum |
| rdy | output | 1 | Engine will accept a word |
| ack | output | 1 | One-cycle pulse confirming a word was taken |
| done | output | 1 | Idle with the count at zero |
| ovf | output | 1 | Sticky adder carry for this run |

## Verification
Runs of every length from zero to five are tried with four value patterns:
- All zeros, which separates a real add from a sum that stays at its clear value.
- All maximum values, which forces a carry on the second word and shows that `ovf` is sticky.
- A stepped ascending series, which exposes swapped or missed words through the modulo result.
- A pseudo-random series.

The time `data_vld` is held after `ack` varies from run to run, so duplicate acknowledges or words accepted before release show up. Each run follows one that may have overflowed, which shows whether loading a count clears `ovf`.

// File: rtl/seqsum_pkg.sv
package seqsum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNT_ACK,
        ST_RELEASE,
        ST_FETCH,
        ST_ADD_ACK
    } seq_state_t;

    typedef struct packed {
        logic clr_sum;
        logic ld_sum;
        logic ld_cnt;
        logic dec_cnt;
    } dp_ctrl_t;

endpackage

// File: rtl/seqsum_ctrl.sv
module seqsum_ctrl
    import seqsum_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     data_vld,
    input  logic     cnt_zero,
    output dp_ctrl_t ctl,
    output logic     rdy,
    output logic     ack,
    output logic     idle
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (data_vld) state_d = ST_CNT_ACK;
            ST_CNT_ACK: state_d = ST_RELEASE;
            ST_RELEASE: if (!data_vld) state_d = cnt_zero ? ST_IDLE : ST_FETCH;
            ST_FETCH:   if (data_vld) state_d = ST_ADD_ACK;
            ST_ADD_ACK: state_d = ST_RELEASE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl  = '0;
        rdy  = 1'b0;
        ack  = 1'b0;
        idle = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rdy  = 1'b1;
                idle = 1'b1;
                if (data_vld) begin
                    ctl.clr_sum = 1'b1;
                    ctl.ld_cnt  = 1'b1;
                end
            end
            ST_FETCH: begin
                rdy = 1'b1;
                if (data_vld) begin
                    ctl.ld_sum  = 1'b1;
                    ctl.dec_cnt = 1'b1;
                end
            end
            ST_CNT_ACK, ST_ADD_ACK: ack = 1'b1;
            default: ;
        endcase
    end

    a_r2_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && data_vld) |=> ack);

    a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r4_no_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !rdy);

    a_r6_fetch_only_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> !cnt_zero);

endmodule

// File: rtl/seqsum_dp.sv
module seqsum_dp
    import seqsum_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  dp_ctrl_t          ctl,
    output logic [WORD_W-1:0] sum,
    output logic              cnt_zero,
    output logic              ovf
);

    localparam int ADD_W = WORD_W + 1;

    logic [WORD_W-1:0] sum_q, cnt_q;
    logic              ovf_q;
    logic [ADD_W-1:0]  add_full;

    assign add_full = {1'b0, sum_q} + {1'b0, din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (ctl.clr_sum)     sum_q <= '0;
            else if (ctl.ld_sum) sum_q <= add_full[WORD_W-1:0];

            if (ctl.ld_cnt)       cnt_q <= din;
            else if (ctl.dec_cnt) cnt_q <= cnt_q - 1'b1;

            if (ctl.ld_cnt)      ovf_q <= 1'b0;
            else if (ctl.ld_sum) ovf_q <= ovf_q | add_full[WORD_W];
        end
    end

    assign sum      = sum_q;
    assign cnt_zero = (cnt_q == '0);
    assign ovf      = ovf_q;

    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_cnt |=> (sum_q == '0) && !ovf_q && (cnt_q == $past(din)));

    a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.dec_cnt |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ctl.ld_cnt) |=> ovf_q);

endmodule

// File: rtl/seqsum_top.sv
module seqsum_top
    import seqsum_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_bus,
    input  logic              data_vld,
    output logic [WORD_W-1:0] out_bus,
    output logic              rdy,
    output logic              ack,
    output logic              done,
    output logic              ovf
);

    dp_ctrl_t ctl;
    logic     cnt_zero;
    logic     idle;

    seqsum_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_vld (data_vld),
        .cnt_zero (cnt_zero),
        .ctl      (ctl),
        .rdy      (rdy),
        .ack      (ack),
        .idle     (idle)
    );

    seqsum_dp #(.WORD_W(WORD_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (in_bus),
        .ctl      (ctl),
        .sum      (out_bus),
        .cnt_zero (cnt_zero),
        .ovf      (ovf)
    );

    assign done = idle && cnt_zero;

    a_r6_done_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rdy);

endmodule

// File: tb/seqsum_top_bench.sv
module seqsum_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int MAXN       = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_bus = '0;
    logic         data_vld = 1'b0;
    logic [W-1:0] out_bus;
    logic         rdy, ack, done, ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqsum_top #(.WORD_W(W)) u_seqsum_top (
        .clk(clk), .rst_n(rst_n), .in_bus(in_bus), .data_vld(data_vld),
        .out_bus(out_bus), .rdy(rdy), .ack(ack), .done(done), .ovf(ovf)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [W-1:0] v, input int hold, input bit first);
        int acks;
        int waited;
        acks = 0;
        waited = 0;
        while (!rdy && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check("R4 ready before send", int'(rdy), 1);
        in_bus   = v;
        data_vld = 1'b1;
        for (int c = 0; c < hold + 2; c++) begin
            @(negedge clk);
            if (ack) acks++;
            if (c == 0) begin
                check("R2 ack follows accept", int'(ack), 1);
                if (first) begin
                    check("R2 sum cleared", int'(out_bus), 0);
                    check("R7 ovf cleared on load", int'(ovf), 0);
                end
            end else begin
                check("R4 rdy low until release", int'(rdy), 0);
            end
        end
        check("R3 single ack", acks, 1);
        data_vld = 1'b0;
        in_bus   = '0;
        @(negedge clk);
        check("R4 rdy after release", int'(rdy), 1);
    endtask

    function automatic logic [W-1:0] pat_val(int p, int i, int seed);
        case (p)
            0: return '0;
            1: return '1;
            2: return W'((i + 1) * 3);
            default: return W'((seed * 5 + i * 7 + 3) ^ (i << 1));
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdy", int'(rdy), 1);
        check("R1 ack", int'(ack), 0);
        check("R1 out_bus", int'(out_bus), 0);
        check("R1 ovf", int'(ovf), 0);
        check("R1 done", int'(done), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n <= MAXN; n++) begin
                int sum_full;
                int hold;
                hold = (n + p) % 3;
                sum_full = 0;
                send_word(W'(n), hold, 1'b1);
                if (n == 0) begin
                    check("R8 zero count sum", int'(out_bus), 0);
                    check("R8 zero count done", int'(done), 1);
                end else begin
                    check("R6 done low mid-run", int'(done), 0);
                end
                for (int i = 0; i < n; i++) begin
                    logic [W-1:0] v;
                    v = pat_val(p, i, n);
                    sum_full += int'(v);
                    send_word(v, hold, 1'b0);
                    check("R5 running sum", int'(out_bus), sum_full % (1 << W));
                    check("R7 ovf so far", int'(ovf), int'(sum_full >= (1 << W)));
                    if (i < n - 1) check("R6 done low mid-run", int'(done), 0);
                end
                check("R6 done at end", int'(done), 1);
                check("R6 rdy at end", int'(rdy), 1);
                check("R5 final sum", int'(out_bus), sum_full % (1 << W));
                check("R7 final ovf", int'(ovf), int'(sum_full >= (1 << W)));
            end
        end
        finished = 1;
    end

    initial begin
        for (int t = 0; t < 20000 && !finished; t++) @(negedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule